// File: doc/BRIEF.md
# CAN Receive Queue with Identifier Acceptance Filter

This block sits behind a CAN receive engine. Each finished frame comes in on a valid/ready stream. The block tests the frame against a table of eight 32-bit filter words. If any filter in the table accepts the frame, the frame goes into a six-slot receive queue. The host sees the oldest unread frame on a parallel output view. It takes that frame off the queue by raising the ready of the output stream.

One global format code sets how every word in the table is read. In the first format a word is one full identifier filter with its own remote and extended qualifiers. In the second format a word holds two half-width filters, each with its own qualifiers. In the third format a word holds four 8-bit identifier prefixes that ignore the qualifiers. This gives 8, 16 or 32 filters.

Back-pressure rules: the input stream is never stalled, so `rx_ready` stays high. When the queue is full, an accepted frame is discarded and the overflow flag is set. The output stream presents a frame whenever `q_valid` is high. A cycle with `q_valid` and `q_ready` both high removes that frame. `q_ready` with `q_valid` low does nothing.

Top module: `can_rxfifo_filter`

## Requirements
- R1: The filter table holds 8 words of 32 bits, written through `tw_en`/`tw_addr`/`tw_data`. A frame presented in the same cycle as a write is tested against the old word. A frame presented in any later cycle is tested against the new word. Reset clears every word to zero.
- R2: `fmt_sel` selects the format for the whole table: 0 = full-identifier format, 1 = dual-filter format, 2 = prefix format, 3 = no filter accepts any frame.
- R3: Full-identifier format. Bit 31 is the remote qualifier and bit 30 is the extended qualifier. Both must equal the frame's RTR and IDE. A standard frame then needs word bits 29:19 equal to identifier bits 28:18. An extended frame needs word bits 29:1 equal to identifier bits 28:0.
- R4: Dual-filter format. The upper half (bits 31:16) and the lower half (bits 15:0) are independent filters. Within each half, bit 15 is the remote qualifier and bit 14 is the extended qualifier, and both must match. A standard frame needs half bits 13:3 equal to identifier bits 28:18. An extended frame needs half bits 13:0 equal to identifier bits 28:15.
- R5: Prefix format. Each of the four bytes of a word is a filter. It accepts any frame whose identifier bits 28:21 equal that byte, regardless of IDE and RTR.
- R6: A frame is stored when any filter in any table word accepts it. A frame that no filter accepts leaves the queue and the outputs unchanged.
- R7: A frame taken on a rising edge (`rx_valid` high) is tested at that edge. If accepted, it is written into the queue on the following edge. `q_valid` can therefore rise no earlier than after the second edge.
- R8: The queue holds up to 6 frames and delivers them oldest first. The `q_*` fields present the head frame unchanged until it is popped. `q_count` gives the number of stored frames.
- R9: An accepted frame that arrives when the queue is full, with no pop in the same cycle, is discarded. In that case `ovf` is set. It stays set until a cycle with `ovf_clr` high and no new overflow.
- R10: `q_ready` while the queue is empty has no effect on the count or on later frames.
- R11: `rx_ready` is high in every cycle.
- R12: After reset, `q_valid` = 0, `q_count` = 0 and `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Incoming frame valid |
| rx_ready | output | 1 | Always high |
| rx_ide | input | 1 | Extended-frame flag |
| rx_srr | input | 1 | Substitute remote request bit |
| rx_rtr | input | 1 | Remote-frame flag |
| rx_len | input | 4 | Data length code |
| rx_stamp | input | 16 | Receive timestamp |
| rx_id | input | 29 | Identifier; standard identifier in bits 28:18 |
| rx_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| tw_en | input | 1 | Table write strobe |
| tw_addr | input | 3 | Table word index |
| tw_data | input | 32 | Table write data |
| fmt_sel | input | 2 | Table format code |
| q_valid | output | 1 | Queue not empty |
| q_ready | input | 1 | Pop the head frame |
| q_ide | output | 1 | Head frame IDE |
| q_srr | output | 1 | Head frame SRR |
| q_rtr | output | 1 | Head frame RTR |
| q_len | output | 4 | Head frame length |
| q_stamp | output | 16 | Head frame timestamp |
| q_id | output | 29 | Head frame identifier |
| q_data | output | 64 | Head frame data bytes |
| q_count | output | 3 | Number of stored frames |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clear overflow flag |

## Verification
The bench drives all inputs just after a falling edge and samples just before the next falling edge. A frame driven in one half-period is tested on the next rising edge and enters the queue on the one after that. Every acceptance check therefore waits two full cycles after the frame before it reads `q_valid`. The latency test also samples after only one edge to confirm that the frame has not yet appeared. Pops, table writes and overflow clears each act on the single rising edge that follows them, so their effect is checked one cycle later.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int ID_W    = 29;
  localparam int LEN_W   = 4;
  localparam int STAMP_W = 16;
  localparam int DATA_W  = 64;
  localparam int WORD_W  = 32;

  typedef enum logic [1:0] {
    FMT_FULL = 2'd0,
    FMT_DUAL = 2'd1,
    FMT_PFX  = 2'd2,
    FMT_OFF  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic               ide;
    logic               srr;
    logic               rtr;
    logic [LEN_W-1:0]   len;
    logic [STAMP_W-1:0] stamp;
    logic [ID_W-1:0]    id;
    logic [DATA_W-1:0]  data;
  } frame_t;

  // one full-identifier filter per word
  function automatic logic hit_full(input logic [WORD_W-1:0] w, input logic ide,
                                    input logic rtr, input logic [ID_W-1:0] id);
    logic q;
    q = (w[31] == rtr) && (w[30] == ide);
    if (ide) return q && (w[29:1] == id);
    return q && (w[29:19] == id[28:18]);
  endfunction

  // one half-word filter
  function automatic logic hit_half(input logic [15:0] h, input logic ide,
                                    input logic rtr, input logic [ID_W-1:0] id);
    logic q;
    q = (h[15] == rtr) && (h[14] == ide);
    if (ide) return q && (h[13:0] == id[28:15]);
    return q && (h[13:3] == id[28:18]);
  endfunction

  // identifier prefix filter, qualifiers ignored
  function automatic logic hit_pfx(input logic [7:0] b, input logic [ID_W-1:0] id);
    return b == id[28:21];
  endfunction
endpackage

// File: rtl/can_rxf_table.sv
module can_rxf_table
  import can_rxf_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [1:0]               fmt,
  input  logic                     ide,
  input  logic                     rtr,
  input  logic [ID_W-1:0]          id,
  output logic                     hit
);
  localparam int HALVES = 2 * WORDS;
  localparam int BYTES  = 4 * WORDS;

  logic [WORD_W-1:0] tbl [WORDS];
  logic [WORDS-1:0]  h_full;
  logic [HALVES-1:0] h_dual;
  logic [BYTES-1:0]  h_pfx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  for (genvar e = 0; e < WORDS; e++) begin : g_word
    assign h_full[e] = hit_full(tbl[e], ide, rtr, id);
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign h_dual[2*e+h] = hit_half(tbl[e][16*h +: 16], ide, rtr, id);
    end
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign h_pfx[4*e+b] = hit_pfx(tbl[e][8*b +: 8], id);
    end
  end

  always_comb begin
    unique case (fmt_e'(fmt))
      FMT_FULL: hit = |h_full;
      FMT_DUAL: hit = |h_dual;
      FMT_PFX:  hit = |h_pfx;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/can_rxf_fifo.sv
module can_rxf_fifo #(
  parameter int DEPTH = 6,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       not_empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, do_pop, do_push;

  assign full      = (count == FULLC);
  assign not_empty = (count != '0);
  assign do_pop    = pop && not_empty;
  assign do_push   = push && (!full || do_pop);
  assign drop      = push && !do_push;
  assign rdata     = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/can_rxfifo_filter.sv
module can_rxfifo_filter
  import can_rxf_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  output logic                         rx_ready,
  input  logic                         rx_ide,
  input  logic                         rx_srr,
  input  logic                         rx_rtr,
  input  logic [3:0]                   rx_len,
  input  logic [15:0]                  rx_stamp,
  input  logic [28:0]                  rx_id,
  input  logic [63:0]                  rx_data,
  input  logic                         tw_en,
  input  logic [$clog2(WORDS)-1:0]     tw_addr,
  input  logic [31:0]                  tw_data,
  input  logic [1:0]                   fmt_sel,
  output logic                         q_valid,
  input  logic                         q_ready,
  output logic                         q_ide,
  output logic                         q_srr,
  output logic                         q_rtr,
  output logic [3:0]                   q_len,
  output logic [15:0]                  q_stamp,
  output logic [28:0]                  q_id,
  output logic [63:0]                  q_data,
  output logic [$clog2(DEPTH+1)-1:0]   q_count,
  output logic                         ovf,
  input  logic                         ovf_clr
);
  localparam int FW = $bits(frame_t);

  frame_t in_f, stg_f, head_f;
  logic   hit, stg_vld, stg_hit, drop;

  assign rx_ready = 1'b1;
  assign in_f = '{ide: rx_ide, srr: rx_srr, rtr: rx_rtr, len: rx_len,
                  stamp: rx_stamp, id: rx_id, data: rx_data};

  can_rxf_table #(.WORDS(WORDS)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tw_en), .waddr(tw_addr), .wdata(tw_data),
    .fmt(fmt_sel), .ide(rx_ide), .rtr(rx_rtr), .id(rx_id), .hit(hit)
  );

  // match stage: verdict and frame registered together
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_vld <= 1'b0;
      stg_hit <= 1'b0;
      stg_f   <= '0;
    end else begin
      stg_vld <= rx_valid;
      stg_hit <= hit;
      if (rx_valid) stg_f <= in_f;
    end
  end

  can_rxf_fifo #(.DEPTH(DEPTH), .W(FW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(stg_vld && stg_hit), .wdata(stg_f),
    .pop(q_ready), .rdata(head_f), .not_empty(q_valid), .count(q_count),
    .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (drop)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  assign q_ide   = head_f.ide;
  assign q_srr   = head_f.srr;
  assign q_rtr   = head_f.rtr;
  assign q_len   = head_f.len;
  assign q_stamp = head_f.stamp;
  assign q_id    = head_f.id;
  assign q_data  = head_f.data;
endmodule

// File: rtl/can_rxf_checker.sv
module can_rxf_checker #(
  parameter int DEPTH = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_valid,
  input logic                       rx_ready,
  input logic                       q_valid,
  input logic                       q_ready,
  input logic [28:0]                q_id,
  input logic [63:0]                q_data,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                       ovf,
  input logic                       ovf_clr
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH+1))'(DEPTH)); // R8
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_id) && $stable(q_data)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf); // R9
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(q_count) == ($clog2(DEPTH+1))'(DEPTH)); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> q_count <= 1); // R10
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    q_count > $past(q_count) |-> $past(rx_valid, 2)); // R7
  AST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_ready); // R11
endmodule

bind can_rxfifo_filter can_rxf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .q_valid(q_valid), .q_ready(q_ready), .q_id(q_id), .q_data(q_data),
  .q_count(q_count), .ovf(ovf), .ovf_clr(ovf_clr)
);

// File: tb/can_rxfifo_filter_bench.sv
module can_rxfifo_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic rx_valid = 0, rx_ide = 0, rx_srr = 0, rx_rtr = 0;
  logic [3:0] rx_len = 0;
  logic [15:0] rx_stamp = 0;
  logic [28:0] rx_id = 0;
  logic [63:0] rx_data = 0;
  logic tw_en = 0;
  logic [2:0] tw_addr = 0;
  logic [31:0] tw_data = 0;
  logic [1:0] fmt_sel = 0;
  logic q_ready = 0, ovf_clr = 0;
  logic rx_ready, q_valid, q_ide, q_srr, q_rtr, ovf;
  logic [3:0] q_len;
  logic [15:0] q_stamp;
  logic [28:0] q_id;
  logic [63:0] q_data;
  logic [2:0] q_count;

  int checks = 0;
  int fails = 0;

  can_rxfifo_filter u_can_rxfifo_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_ide(rx_ide), .rx_srr(rx_srr), .rx_rtr(rx_rtr), .rx_len(rx_len),
    .rx_stamp(rx_stamp), .rx_id(rx_id), .rx_data(rx_data), .tw_en(tw_en),
    .tw_addr(tw_addr), .tw_data(tw_data), .fmt_sel(fmt_sel), .q_valid(q_valid),
    .q_ready(q_ready), .q_ide(q_ide), .q_srr(q_srr), .q_rtr(q_rtr),
    .q_len(q_len), .q_stamp(q_stamp), .q_id(q_id), .q_data(q_data),
    .q_count(q_count), .ovf(ovf), .ovf_clr(ovf_clr)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic [31:0] word;
    logic        ide;
    logic        rtr;
    logic [28:0] id;
    logic        hit;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0918_0000, 1'b0, 1'b0, 29'h048C_0000, 1'b1},
    '{2'd0, 32'h0918_0000, 1'b0, 1'b1, 29'h048C_0000, 1'b0},
    '{2'd0, 32'h0918_0000, 1'b0, 1'b0, 29'h0490_0000, 1'b0},
    '{2'd0, 32'h7579_BDE2, 1'b1, 1'b0, 29'h1ABC_DEF1, 1'b1},
    '{2'd0, 32'h7579_BDE2, 1'b0, 1'b0, 29'h1ABC_DEF1, 1'b0},
    '{2'd1, 32'h1550_FFFF, 1'b0, 1'b0, 29'h0AA8_0000, 1'b1},
    '{2'd1, 32'hFFFF_6D5A, 1'b1, 1'b0, 29'h16AD_1234, 1'b1},
    '{2'd1, 32'hFFFF_6D5A, 1'b1, 1'b0, 29'h16AD_9234, 1'b0},
    '{2'd1, 32'hFFFF_AF80, 1'b0, 1'b1, 29'h17C0_0000, 1'b1},
    '{2'd2, 32'h1122_3344, 1'b0, 1'b1, 29'h0674_0000, 1'b1},
    '{2'd2, 32'h1122_3344, 1'b1, 1'b0, 29'h0881_FFFF, 1'b1},
    '{2'd2, 32'h1122_3344, 1'b0, 1'b0, 29'h0AA0_0000, 1'b0},
    '{2'd3, 32'h0000_0000, 1'b0, 1'b0, 29'h0000_0000, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic twrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    tw_en = 1; tw_addr = a; tw_data = d;
    @(negedge clk);
    tw_en = 0;
  endtask

  task automatic drive(input logic ide, input logic rtr, input logic [28:0] id, input int tag);
    rx_valid = 1; rx_ide = ide; rx_srr = ide; rx_rtr = rtr; rx_len = 4'd8;
    rx_stamp = 16'h1000 + 16'(tag); rx_id = id;
    rx_data = 64'h0102_0304_0506_0708 + 64'(tag);
  endtask

  // present one frame for one cycle, return at the negedge after the match edge
  task automatic send(input logic ide, input logic rtr, input logic [28:0] id, input int tag);
    @(negedge clk);
    drive(ide, rtr, id, tag);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic pop1;
    @(negedge clk);
    q_ready = 1;
    @(negedge clk);
    q_ready = 0;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    string rq;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state, R11 ready
    chk(q_valid == 0, "R12 q_valid", q_valid, 0);
    chk(q_count == 0, "R12 q_count", q_count, 0);
    chk(ovf == 0, "R12 ovf", ovf, 0);
    chk(rx_ready == 1, "R11 rx_ready", rx_ready, 1);

    for (int w = 0; w < 8; w++) twrite(3'(w), 32'hFFFF_FFFF);

    for (int i = 0; i < NV; i++) begin
      rq = (VECS[i].fmt == 2'd0) ? "R3" : (VECS[i].fmt == 2'd1) ? "R4" :
           (VECS[i].fmt == 2'd2) ? "R5" : "R2";
      fmt_sel = VECS[i].fmt;
      twrite(3'd0, VECS[i].word);
      send(VECS[i].ide, VECS[i].rtr, VECS[i].id, i);
      @(negedge clk);
      chk(q_valid == VECS[i].hit, {rq, " accept"}, q_valid, VECS[i].hit);
      if (VECS[i].hit) begin
        chk(q_id == VECS[i].id && q_ide == VECS[i].ide && q_rtr == VECS[i].rtr &&
            q_srr == VECS[i].ide && q_len == 4'd8 && q_stamp == 16'h1000 + 16'(i) &&
            q_data == 64'h0102_0304_0506_0708 + 64'(i), {rq, " fields"}, q_id, VECS[i].id);
        pop1();
      end
      chk(q_count == 0, "R6 count after vector", q_count, 0);
    end

    // R7 latency: not visible after one edge, visible after two
    fmt_sel = 2'd2;
    twrite(3'd0, 32'h1122_3344);
    send(1'b0, 1'b0, 29'h0674_0000, 20);
    chk(q_valid == 0, "R7 early", q_valid, 0);
    @(negedge clk);
    chk(q_valid == 1, "R7 due", q_valid, 1);
    pop1();

    // R1 write and frame in same cycle use the old word
    @(negedge clk);
    tw_en = 1; tw_addr = 3'd0; tw_data = 32'h7700_0000;
    drive(1'b0, 1'b0, 29'h0EE0_0000, 21);
    @(negedge clk);
    tw_en = 0; rx_valid = 0;
    @(negedge clk);
    chk(q_valid == 0, "R1 old word", q_valid, 0);
    send(1'b0, 1'b0, 29'h0EE0_0000, 22);
    @(negedge clk);
    chk(q_valid == 1, "R1 new word", q_valid, 1);
    pop1();

    // R6 a filter in a later word alone accepts
    twrite(3'd5, 32'hFFFF_FF99);
    send(1'b1, 1'b1, 29'h1320_0005, 23);
    @(negedge clk);
    chk(q_valid == 1 && q_id == 29'h1320_0005, "R6 word5", q_id, 29'h1320_0005);
    pop1();

    // R8 R9 fill past depth
    @(negedge clk);
    for (int k = 0; k < 7; k++) begin
      drive(1'b0, 1'b0, 29'h0EE0_0000 + 29'(k), 30 + k);
      @(negedge clk);
    end
    rx_valid = 0;
    @(negedge clk);
    chk(q_count == 3'd6, "R8 full count", q_count, 6);
    chk(ovf == 1, "R9 ovf set", ovf, 1);
    for (int k = 0; k < 6; k++) begin
      chk(q_id == 29'h0EE0_0000 + 29'(k), "R8 order", q_id, 29'h0EE0_0000 + 29'(k));
      pop1();
    end
    chk(q_count == 0 && ovf == 1, "R9 sticky", ovf, 1);
    @(negedge clk);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    chk(ovf == 0, "R9 clear", ovf, 0);

    // R10 pop on empty
    @(negedge clk);
    q_ready = 1;
    repeat (2) @(negedge clk);
    q_ready = 0;
    chk(q_count == 0, "R10 empty pop", q_count, 0);
    send(1'b0, 1'b0, 29'h0EE0_0042, 40);
    @(negedge clk);
    chk(q_count == 1 && q_id == 29'h0EE0_0042, "R10 after", q_id, 29'h0EE0_0042);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule